// File: doc/BRIEF.md
# Circular-Buffer Address Stepper

This block works out the value an address register takes after a memory access that steps the pointer forward. The step is a power of two (1, 2 or 4), chosen by a 2-bit size code. In plain mode the pointer simply advances by the step, and the 16-bit sum rolls over. In circular mode the block compares the pointer with a buffer-limit register. The limit is first rounded down to a multiple of the step. When the two match, the pointer is reloaded from a buffer-base register instead of being advanced, and a one-cycle wrap flag is raised.

The base register, the limit register and the circular-mode flag sit in a small register bank inside the block. Each has its own write strobe. The stepped pointer is captured on a clock enable, so a load/store unit can drive the present pointer and the size code, pulse the enable, and read back the new pointer and wrap flag one cycle later.

Top module: `modaddr_step_unit`

## Requirements
- R1: A synchronous reset clears the base register, the limit register, the circular-mode flag, `next_addr` and `wrapped`.
- R2: The size code picks the step: 0 gives 1, 1 gives 2, 2 gives 4, and 3 also gives 4.
- R3: With the circular-mode flag clear, a step yields `cur_addr` plus the step, and `wrapped` stays 0, whatever the base and limit hold.
- R4: With the circular-mode flag set and `cur_addr` equal to the limit with its low log2(step) bits cleared, a step yields the base register and sets `wrapped` to 1.
- R5: With the circular-mode flag set and no match, a step yields `cur_addr` plus the step, and `wrapped` is 0.
- R6: In a cycle where `step_en` is low, `next_addr` keeps its value and `wrapped` drops to 0 on the following edge, so each wrap shows as a flag for exactly the steps that reload.
- R7: A write to the base register, the limit register or the mode flag takes effect from the next cycle on. A step in the same cycle as the write uses the earlier values.
- R8: The low bits of the limit that lie below the step size are ignored in the match. For a limit of 0x1003, the match address is 0x1003 for a step of 1, 0x1002 for a step of 2 and 0x1000 for a step of 4.
- R9: The addition wraps modulo 2^16 (0xFFFF plus 1 gives 0x0000), and this roll-over does not raise `wrapped`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| base_we | input | 1 | Write strobe for the buffer-base register |
| base_wdata | input | 16 | Value written to the buffer-base register |
| limit_we | input | 1 | Write strobe for the buffer-limit register |
| limit_wdata | input | 16 | Value written to the buffer-limit register |
| mode_we | input | 1 | Write strobe for the circular-mode flag |
| mode_wdata | input | 1 | Value written to the circular-mode flag |
| step_en | input | 1 | Clock enable: capture the stepped pointer this cycle |
| cur_addr | input | 16 | Present value of the address register |
| size_code | input | 2 | Step size code (0: 1, 1: 2, 2 and 3: 4) |
| next_addr | output | 16 | Registered stepped pointer |
| wrapped | output | 1 | High for one cycle when the step reloaded the base |

## Verification
A configuration write and a pointer step can land in the same cycle. The bench provokes this by rewriting the base register while it steps a pointer that sits on the limit. It then judges that the step reloads the old base, and that the very next step reloads the newly written one. The same is done for the mode flag around a reset: the bench checks that a cleared flag turns a limit match into a plain add, and that re-arming only the flag brings back a reload of the cleared base.

// File: rtl/modaddr_pkg.sv
package modaddr_pkg;

  typedef enum logic [1:0] {
    SZ_ONE  = 2'd0,
    SZ_TWO  = 2'd1,
    SZ_FOUR = 2'd2,
    SZ_ALT4 = 2'd3
  } step_size_e;

  // log2 of the step selected by a size code (R2)
  function automatic int unsigned size_shift(input logic [1:0] code);
    case (step_size_e'(code))
      SZ_ONE:  return 0;
      SZ_TWO:  return 1;
      default: return 2;
    endcase
  endfunction

endpackage

// File: rtl/modaddr_cfg_regs.sv
module modaddr_cfg_regs #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          base_we,
  input  logic [AW-1:0] base_wdata,
  input  logic          limit_we,
  input  logic [AW-1:0] limit_wdata,
  input  logic          mode_we,
  input  logic          mode_wdata,
  output logic [AW-1:0] base_q,
  output logic [AW-1:0] limit_q,
  output logic          mode_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= '0;
      limit_q <= '0;
      mode_q  <= 1'b0;
    end else begin
      if (base_we)  base_q  <= base_wdata;
      if (limit_we) limit_q <= limit_wdata;
      if (mode_we)  mode_q  <= mode_wdata;
    end
  end

  a_r7_base_write: assert property (@(posedge clk) disable iff (rst)
    base_we |=> base_q == $past(base_wdata));

  a_r7_limit_write: assert property (@(posedge clk) disable iff (rst)
    limit_we |=> limit_q == $past(limit_wdata));

  a_r7_mode_hold: assert property (@(posedge clk) disable iff (rst)
    !mode_we |=> $stable(mode_q));

endmodule

// File: rtl/modaddr_next_calc.sv
module modaddr_next_calc
  import modaddr_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          mode,
  input  logic [1:0]    size_code,
  input  logic [AW-1:0] cur_addr,
  input  logic [AW-1:0] base_addr,
  input  logic [AW-1:0] limit_addr,
  output logic [AW-1:0] step_inc,
  output logic [AW-1:0] limit_aligned,
  output logic          at_limit,
  output logic [AW-1:0] next_addr
);

  localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

  function automatic logic [AW-1:0] step_amount(input int unsigned sh);
    return ONE << sh;
  endfunction

  // power-of-two step: clearing the bits below the step size
  function automatic logic [AW-1:0] align_down(input logic [AW-1:0] v,
                                               input logic [AW-1:0] amt);
    return v & ~(amt - ONE);
  endfunction

  logic [AW-1:0] sum_addr;

  assign step_inc      = step_amount(size_shift(size_code));
  assign limit_aligned = align_down(limit_addr, step_inc);
  assign at_limit      = mode && (cur_addr == limit_aligned);
  assign sum_addr      = cur_addr + step_inc;
  assign next_addr     = at_limit ? base_addr : sum_addr;

endmodule

// File: rtl/modaddr_step_unit.sv
module modaddr_step_unit #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          base_we,
  input  logic [AW-1:0] base_wdata,
  input  logic          limit_we,
  input  logic [AW-1:0] limit_wdata,
  input  logic          mode_we,
  input  logic          mode_wdata,
  input  logic          step_en,
  input  logic [AW-1:0] cur_addr,
  input  logic [1:0]    size_code,
  output logic [AW-1:0] next_addr,
  output logic          wrapped
);

  logic [AW-1:0] base_q, limit_q;
  logic          mode_q;
  logic [AW-1:0] step_inc, limit_aligned, calc_next;
  logic          at_limit;

  modaddr_cfg_regs #(.AW(AW)) u_cfg (
    .clk         (clk),
    .rst         (rst),
    .base_we     (base_we),
    .base_wdata  (base_wdata),
    .limit_we    (limit_we),
    .limit_wdata (limit_wdata),
    .mode_we     (mode_we),
    .mode_wdata  (mode_wdata),
    .base_q      (base_q),
    .limit_q     (limit_q),
    .mode_q      (mode_q)
  );

  modaddr_next_calc #(.AW(AW)) u_calc (
    .mode          (mode_q),
    .size_code     (size_code),
    .cur_addr      (cur_addr),
    .base_addr     (base_q),
    .limit_addr    (limit_q),
    .step_inc      (step_inc),
    .limit_aligned (limit_aligned),
    .at_limit      (at_limit),
    .next_addr     (calc_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      next_addr <= '0;
      wrapped   <= 1'b0;
    end else begin
      wrapped <= step_en && at_limit;
      if (step_en) next_addr <= calc_next;
    end
  end

  a_r6_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    !step_en |=> $stable(next_addr));

  a_r6_no_flag_when_idle: assert property (@(posedge clk) disable iff (rst)
    !step_en |=> !wrapped);

  a_r4_reload_base: assert property (@(posedge clk) disable iff (rst)
    (step_en && at_limit) |=> (wrapped && next_addr == $past(base_q)));

  a_r3_plain_add: assert property (@(posedge clk) disable iff (rst)
    (step_en && !mode_q) |=> (!wrapped && next_addr == $past(cur_addr + step_inc)));

  a_r8_match_aligned: assert property (@(posedge clk) disable iff (rst)
    (step_en && mode_q && cur_addr != limit_aligned) |=> !wrapped);

endmodule

// File: tb/modaddr_step_unit_bench.sv
`timescale 1ns/1ps
module modaddr_step_unit_bench;

  logic        clk = 1'b0;
  logic        rst;
  logic        base_we, limit_we, mode_we, mode_wdata, step_en;
  logic [15:0] base_wdata, limit_wdata, cur_addr;
  logic [1:0]  size_code;
  logic [15:0] next_addr;
  logic        wrapped;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  modaddr_step_unit u_modaddr_step_unit (
    .clk(clk), .rst(rst),
    .base_we(base_we), .base_wdata(base_wdata),
    .limit_we(limit_we), .limit_wdata(limit_wdata),
    .mode_we(mode_we), .mode_wdata(mode_wdata),
    .step_en(step_en), .cur_addr(cur_addr), .size_code(size_code),
    .next_addr(next_addr), .wrapped(wrapped)
  );

  typedef struct packed {
    logic        md;
    logic [1:0]  sz;
    logic [15:0] bs;
    logic [15:0] lm;
    logic [15:0] cur;
    logic [15:0] nx;
    logic        wr;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd0, 16'h0000, 16'h0000, 16'h1234, 16'h1235, 1'b0}, // R2 R3 step 1
    '{1'b0, 2'd1, 16'h0000, 16'h0000, 16'h1234, 16'h1236, 1'b0}, // R2 step 2
    '{1'b0, 2'd2, 16'h0000, 16'h0000, 16'h1234, 16'h1238, 1'b0}, // R2 step 4
    '{1'b0, 2'd3, 16'h0000, 16'h0000, 16'h1234, 16'h1238, 1'b0}, // R2 code 3
    '{1'b0, 2'd0, 16'h0000, 16'h0000, 16'hFFFF, 16'h0000, 1'b0}, // R9 roll-over
    '{1'b0, 2'd2, 16'h0100, 16'h0200, 16'h0200, 16'h0204, 1'b0}, // R3 limit ignored
    '{1'b1, 2'd0, 16'h0100, 16'h0200, 16'h0200, 16'h0100, 1'b1}, // R4 reload
    '{1'b1, 2'd0, 16'h0100, 16'h0200, 16'h01FF, 16'h0200, 1'b0}, // R5 no match
    '{1'b1, 2'd2, 16'h0F00, 16'h1003, 16'h1000, 16'h0F00, 1'b1}, // R8 step 4
    '{1'b1, 2'd0, 16'h0F00, 16'h1003, 16'h1000, 16'h1001, 1'b0}, // R8 step 1
    '{1'b1, 2'd1, 16'h0F00, 16'h1003, 16'h1002, 16'h0F00, 1'b1}, // R8 step 2
    '{1'b1, 2'd2, 16'h0000, 16'hFFFF, 16'hFFF8, 16'hFFFC, 1'b0}, // R5 near top
    '{1'b1, 2'd2, 16'h0000, 16'hFFFF, 16'hFFFC, 16'h0000, 1'b1}  // R4 top wrap
  };

  task automatic check(input string req, input logic [15:0] act_a, input logic [15:0] exp_a,
                       input logic act_w, input logic exp_w);
    checks++;
    if (act_a !== exp_a || act_w !== exp_w) begin
      errors++;
      $display("FAIL %s: next_addr=%h wrapped=%b, expected next_addr=%h wrapped=%b",
               req, act_a, act_w, exp_a, exp_w);
    end
  endtask

  task automatic cfg_write(input logic md, input logic [15:0] bs, input logic [15:0] lm);
    @(negedge clk);
    step_en = 1'b0;
    base_we = 1'b1; base_wdata = bs;
    limit_we = 1'b1; limit_wdata = lm;
    mode_we = 1'b1; mode_wdata = md;
    @(negedge clk);
    base_we = 1'b0; limit_we = 1'b0; mode_we = 1'b0;
  endtask

  // called at a negedge; result sampled at the following negedge
  task automatic step(input logic [15:0] a, input logic [1:0] sz);
    step_en = 1'b1; cur_addr = a; size_code = sz;
    @(negedge clk);
    step_en = 1'b0;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; base_we = 0; limit_we = 0; mode_we = 0; mode_wdata = 0;
    base_wdata = 0; limit_wdata = 0; step_en = 0; cur_addr = 0; size_code = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 reset state", next_addr, 16'h0000, wrapped, 1'b0);

    for (int i = 0; i < NV; i++) begin
      cfg_write(VECS[i].md, VECS[i].bs, VECS[i].lm);
      step(VECS[i].cur, VECS[i].sz);
      check($sformatf("R2/R3/R4/R5/R8/R9 vector %0d", i), next_addr, VECS[i].nx,
            wrapped, VECS[i].wr);
    end

    // R6: idle cycle after a wrap
    @(negedge clk);
    check("R6 idle holds and clears flag", next_addr, 16'h0000, wrapped, 1'b0);

    // R7: base write in the same cycle as a reloading step
    cfg_write(1'b1, 16'h0010, 16'h0400);
    base_we = 1'b1; base_wdata = 16'h0AAA;
    step_en = 1'b1; cur_addr = 16'h0400; size_code = 2'd0;
    @(negedge clk);
    base_we = 1'b0;
    check("R7 same-cycle write uses old base", next_addr, 16'h0010, wrapped, 1'b1);
    @(negedge clk);
    step_en = 1'b0;
    check("R7 next step uses new base", next_addr, 16'h0AAA, wrapped, 1'b1);

    // R1: reset clears mode, limit and base
    cfg_write(1'b1, 16'h0050, 16'h0300);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 outputs after reset", next_addr, 16'h0000, wrapped, 1'b0);
    step(16'h0000, 2'd0);
    check("R1 mode cleared by reset", next_addr, 16'h0001, wrapped, 1'b0);
    mode_we = 1'b1; mode_wdata = 1'b1;
    @(negedge clk);
    mode_we = 1'b0;
    step(16'h0000, 2'd0);
    check("R1 base and limit cleared by reset", next_addr, 16'h0000, wrapped, 1'b1);

    // R6: enable low with a matching pointer still leaves everything alone
    cur_addr = 16'h0000;
    @(negedge clk);
    check("R6 no step without enable", next_addr, 16'h0000, wrapped, 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule